// File: doc/BRIEF.md
# Cascadable Multiply-Accumulate Slice

This block is a pipelined signed arithmetic slice. Two 18-bit two's-complement operands go into a dedicated multiplier. The 36-bit product, a 48-bit side operand, the slice's own registered result and a result arriving from a neighbouring slice are the candidates for a three-input adder/subtracter that produces a 48-bit result. A 7-bit mode word, sampled every cycle, picks the adder operands. The same hardware can therefore act as a multiplier, a wide adder, an accumulator, a multiply-accumulate unit, one stage of a cascaded sum, or a wide multiplexer.

Slices chain without glue logic. The B operand leaves through a dedicated cascade output and can enter the next slice in place of its own B pin. The result leaves through a 48-bit cascade output that feeds the next slice's cascade input, either unchanged or shifted right arithmetically by 17 bits. Each register stage is enabled by a parameter: A/B inputs, C input, mode/subtract controls, product, and result. Each enabled stage has its own synchronous reset and clock enable. When all stages are enabled, the slice takes new operands and returns one result every clock. Feedback modes need the result register enabled.

The mode word is laid out as follows:
- bits [1:0] are the X field: 00 zero, 01 product, 10 result, 11 A:B concatenated.
- bits [3:2] are the Y field: 00 zero, 01 product, 11 C.
- bits [6:4] are the Z field: 000 zero, 001 cascade-in, 010 result, 011 C, 101 cascade-in>>>17, 110 result>>>17.

Top module: `mac_slice`

## Requirements
- R1: A synchronous reset of a stage clears that stage's register on the next clock. After all resets, `p`, `pcout` and `bcout` read zero.
- R2: With the X field and the Y field both 01 and the Z field 000, `p` equals the signed product A×B, sign-extended to 48 bits. This value appears three clocks after the operands are presented in the default configuration. The product may only be selected in X and Y together; it is then counted once. Y=10 and Z values 100 and 111 are reserved.
- R3: When `subtract` is 1, the slice computes Z − (X + Y). When `subtract` is 0, it computes Z + X + Y.
- R4: Y=11 and Z=011 select C. X=11 selects {A,B} as a 36-bit signed value, sign-extended to 48 bits. With X=Y=00, the slice passes C through unchanged.
- R5: With the Z field 010 and the product selected, each clock with `ce_p` high adds the product to `p`.
- R6: Z=110 feeds `p` arithmetically shifted right by 17 back into the adder. Z=101 does the same with `pcin`.
- R7: Z=001 adds `pcin`. `pcout` always equals `p`, so a chain of slices forms a running sum.
- R8: `bcout` carries the B operand after the B input register. When the parameter `B_FROM_CASCADE` is 1, the slice takes B from `bcin` and ignores the `b` pin.
- R9: While a stage's clock enable is low, that stage's register holds its value.
- R10: The sum wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ab | input | 1 | Synchronous reset, A/B input registers |
| rst_c | input | 1 | Synchronous reset, C register |
| rst_ctl | input | 1 | Synchronous reset, mode/subtract register |
| rst_m | input | 1 | Synchronous reset, product register |
| rst_p | input | 1 | Synchronous reset, result register |
| ce_ab | input | 1 | Clock enable, A/B input registers |
| ce_c | input | 1 | Clock enable, C register |
| ce_ctl | input | 1 | Clock enable, mode/subtract register |
| ce_m | input | 1 | Clock enable, product register |
| ce_p | input | 1 | Clock enable, result register |
| a | input | 18 | Signed multiplier operand A |
| b | input | 18 | Signed multiplier operand B |
| bcin | input | 18 | B operand arriving from the previous slice |
| c | input | 48 | Side operand C |
| pcin | input | 48 | Result arriving from the previous slice |
| opmode | input | 7 | Operand-select mode word |
| subtract | input | 1 | 1 selects Z − (X + Y) |
| p | output | 48 | Result |
| pcout | output | 48 | Result toward the next slice |
| bcout | output | 18 | Registered B toward the next slice |

## Verification
The assertions take for granted that the registered mode word is never a reserved code: the product must be chosen in X and Y together, and Y=10 and Z=100/111 are never used. The bench drives only legal words, changes them only at clock midpoints and moves through the listed modes. The held-value and shift checks also assume that no other stage reset fires while their window is open. The bench keeps every reset low outside the deliberate reset pulses.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

  typedef enum logic [1:0] {
    XS_ZERO = 2'b00,
    XS_PROD = 2'b01,
    XS_RES  = 2'b10,
    XS_AB   = 2'b11
  } xsel_e;

  typedef enum logic [1:0] {
    YS_ZERO = 2'b00,
    YS_PROD = 2'b01,
    YS_RSVD = 2'b10,
    YS_C    = 2'b11
  } ysel_e;

  typedef enum logic [2:0] {
    ZS_ZERO     = 3'b000,
    ZS_CASC     = 3'b001,
    ZS_RES      = 3'b010,
    ZS_C        = 3'b011,
    ZS_RSVD4    = 3'b100,
    ZS_CASC_SHR = 3'b101,
    ZS_RES_SHR  = 3'b110,
    ZS_RSVD7    = 3'b111
  } zsel_e;

  localparam int MODE_W    = 7;
  localparam int CASC_SHR  = 17;

  function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
    logic ok;
    ok = 1'b1;
    if ((m[1:0] == XS_PROD) != (m[3:2] == YS_PROD)) ok = 1'b0;
    if (m[3:2] == YS_RSVD) ok = 1'b0;
    if (m[6:4] == ZS_RSVD4 || m[6:4] == ZS_RSVD7) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
  parameter int W  = 8,
  parameter int EN = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN != 0) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end
      assign q = q_r;

      // R1: reset clears the stage on the following edge
      a_r1_sync_clear: assert property (@(posedge clk) rst |=> (q == '0));
      // R9: a disabled stage keeps its contents
      a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst, ce};
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/mac_opmux.sv
module mac_opmux
  import mac_slice_pkg::*;
#(
  parameter int MW = 36,
  parameter int CW = 48,
  parameter int PW = 48
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [MW-1:0]     prod,
  input  logic [MW-1:0]     ab_cat,
  input  logic [CW-1:0]     c_op,
  input  logic [PW-1:0]     res_fb,
  input  logic [PW-1:0]     casc_in,
  output logic [PW-1:0]     x_op,
  output logic [PW-1:0]     y_op,
  output logic [PW-1:0]     z_op
);

  localparam int EXT = PW - MW;

  logic [PW-1:0] prod_ext;
  logic [PW-1:0] ab_ext;
  logic [PW-1:0] c_ext;
  logic [PW-1:0] casc_shr;
  logic [PW-1:0] res_shr;
  xsel_e xs;
  ysel_e ys;
  zsel_e zs;

  assign prod_ext = {{EXT{prod[MW-1]}}, prod};
  assign ab_ext   = {{EXT{ab_cat[MW-1]}}, ab_cat};
  assign c_ext    = PW'(c_op);
  assign casc_shr = $signed(casc_in) >>> CASC_SHR;
  assign res_shr  = $signed(res_fb) >>> CASC_SHR;

  assign xs = xsel_e'(mode[1:0]);
  assign ys = ysel_e'(mode[3:2]);
  assign zs = zsel_e'(mode[6:4]);

  // The product is carried whole on X; its Y selection contributes zero,
  // so it enters the sum exactly once.
  always_comb begin
    case (xs)
      XS_PROD: x_op = prod_ext;
      XS_RES:  x_op = res_fb;
      XS_AB:   x_op = ab_ext;
      default: x_op = '0;
    endcase
  end

  always_comb begin
    case (ys)
      YS_C:    y_op = c_ext;
      default: y_op = '0;
    endcase
  end

  always_comb begin
    case (zs)
      ZS_CASC:     z_op = casc_in;
      ZS_RES:      z_op = res_fb;
      ZS_C:        z_op = c_ext;
      ZS_CASC_SHR: z_op = casc_shr;
      ZS_RES_SHR:  z_op = res_shr;
      default:     z_op = '0;
    endcase
  end

endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
  parameter int PW = 48
) (
  input  logic [PW-1:0] x_op,
  input  logic [PW-1:0] y_op,
  input  logic [PW-1:0] z_op,
  input  logic          sub,
  output logic [PW-1:0] sum
);

  logic [PW-1:0] xy;

  assign xy  = x_op + y_op;
  assign sum = sub ? (z_op - xy) : (z_op + xy);

endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int AW             = 18,
  parameter int BW             = 18,
  parameter int CW             = 48,
  parameter int PW             = 48,
  parameter int AREG           = 1,
  parameter int BREG           = 1,
  parameter int CREG           = 1,
  parameter int CTLREG         = 1,
  parameter int MREG           = 1,
  parameter int PREG           = 1,
  parameter int B_FROM_CASCADE = 0
) (
  input  logic              clk,
  input  logic              rst_ab,
  input  logic              rst_c,
  input  logic              rst_ctl,
  input  logic              rst_m,
  input  logic              rst_p,
  input  logic              ce_ab,
  input  logic              ce_c,
  input  logic              ce_ctl,
  input  logic              ce_m,
  input  logic              ce_p,
  input  logic [AW-1:0]     a,
  input  logic [BW-1:0]     b,
  input  logic [BW-1:0]     bcin,
  input  logic [CW-1:0]     c,
  input  logic [PW-1:0]     pcin,
  input  logic [MODE_W-1:0] opmode,
  input  logic              subtract,
  output logic [PW-1:0]     p,
  output logic [PW-1:0]     pcout,
  output logic [BW-1:0]     bcout
);

  localparam int MW    = AW + BW;
  localparam int CTL_W = MODE_W + 1;

  logic [BW-1:0]     b_src;
  logic [AW-1:0]     a_q;
  logic [BW-1:0]     b_q;
  logic [CW-1:0]     c_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [MODE_W-1:0] mode_q;
  logic              sub_q;
  logic [MW-1:0]     prod_raw;
  logic [MW-1:0]     m_q;
  logic [PW-1:0]     x_op, y_op, z_op, sum;
  logic [PW-1:0]     p_q;

  generate
    if (B_FROM_CASCADE != 0) begin : g_bsrc_casc
      logic unused_bpin;
      assign unused_bpin = ^b;
      assign b_src = bcin;
    end else begin : g_bsrc_pin
      logic unused_bcin;
      assign unused_bcin = ^bcin;
      assign b_src = b;
    end
  endgenerate

  mac_pipe_reg #(.W(AW), .EN(AREG)) u_areg (
    .clk(clk), .rst(rst_ab), .ce(ce_ab), .d(a), .q(a_q));

  mac_pipe_reg #(.W(BW), .EN(BREG)) u_breg (
    .clk(clk), .rst(rst_ab), .ce(ce_ab), .d(b_src), .q(b_q));

  mac_pipe_reg #(.W(CW), .EN(CREG)) u_creg (
    .clk(clk), .rst(rst_c), .ce(ce_c), .d(c), .q(c_q));

  mac_pipe_reg #(.W(CTL_W), .EN(CTLREG)) u_ctlreg (
    .clk(clk), .rst(rst_ctl), .ce(ce_ctl), .d({subtract, opmode}), .q(ctl_q));

  assign mode_q = ctl_q[MODE_W-1:0];
  assign sub_q  = ctl_q[CTL_W-1];

  assign prod_raw = $signed(a_q) * $signed(b_q);

  mac_pipe_reg #(.W(MW), .EN(MREG)) u_mreg (
    .clk(clk), .rst(rst_m), .ce(ce_m), .d(prod_raw), .q(m_q));

  mac_opmux #(.MW(MW), .CW(CW), .PW(PW)) u_opmux (
    .mode    (mode_q),
    .prod    (m_q),
    .ab_cat  ({a_q, b_q}),
    .c_op    (c_q),
    .res_fb  (p_q),
    .casc_in (pcin),
    .x_op    (x_op),
    .y_op    (y_op),
    .z_op    (z_op)
  );

  mac_addsub #(.PW(PW)) u_addsub (
    .x_op(x_op), .y_op(y_op), .z_op(z_op), .sub(sub_q), .sum(sum));

  mac_pipe_reg #(.W(PW), .EN(PREG)) u_preg (
    .clk(clk), .rst(rst_p), .ce(ce_p), .d(sum), .q(p_q));

  assign p     = p_q;
  assign pcout = p_q;
  assign bcout = b_q;

  // R2: the registered mode word never holds a reserved code
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (rst_ctl)
    mode_is_legal(mode_q));

  generate
    if (BREG != 0) begin : g_bcout_chk
      // R8: the cascade output follows the chosen B source one clock later
      a_r8_bcout_follows: assert property (@(posedge clk) disable iff (rst_ab)
        ce_ab |=> (bcout == $past(b_src)));
    end
    if (PREG != 0) begin : g_shift_chk
      // R6: a shifted feedback alone leaves the top bits all equal
      a_r6_shift_sign: assert property (@(posedge clk) disable iff (rst_p)
        (ce_p && !sub_q && mode_q == {ZS_RES_SHR, YS_ZERO, XS_ZERO})
        |=> ((p[PW-1:PW-1-CASC_SHR] == '0) || (p[PW-1:PW-1-CASC_SHR] == '1)));
    end
  endgenerate

endmodule

// File: tb/mac_slice_bench.sv
module mac_slice_bench;

  localparam int NCH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic        rst_p;
  logic        ce_p;
  logic        ce_all;
  logic [17:0] a, b, bcin;
  logic [47:0] c, pcin;
  logic [6:0]  opmode;
  logic        subtract;
  logic [47:0] p, pcout;
  logic [17:0] bcout;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  mac_slice u_mac_slice (
    .clk(clk), .rst_ab(rst), .rst_c(rst), .rst_ctl(rst), .rst_m(rst),
    .rst_p(rst | rst_p),
    .ce_ab(ce_all), .ce_c(ce_all), .ce_ctl(ce_all), .ce_m(ce_all), .ce_p(ce_p),
    .a(a), .b(b), .bcin(bcin), .c(c), .pcin(pcin),
    .opmode(opmode), .subtract(subtract),
    .p(p), .pcout(pcout), .bcout(bcout));

  logic [17:0] ch_a [NCH];
  logic [17:0] ch_b [NCH];
  logic [17:0] ch_bc [NCH+1];
  logic [47:0] ch_pc [NCH+1];
  logic [47:0] ch_p [NCH];
  logic [6:0]  ch_mode [NCH];

  assign ch_bc[0] = '0;
  assign ch_pc[0] = '0;

  for (genvar k = 0; k < NCH; k++) begin : g_chain
    mac_slice #(.B_FROM_CASCADE(k > 0 ? 1 : 0)) u_link (
      .clk(clk), .rst_ab(rst), .rst_c(rst), .rst_ctl(rst), .rst_m(rst),
      .rst_p(rst),
      .ce_ab(1'b1), .ce_c(1'b1), .ce_ctl(1'b1), .ce_m(1'b1), .ce_p(1'b1),
      .a(ch_a[k]), .b(ch_b[k]), .bcin(ch_bc[k]), .c(48'd0), .pcin(ch_pc[k]),
      .opmode(ch_mode[k]), .subtract(1'b0),
      .p(ch_p[k]), .pcout(ch_pc[k+1]), .bcout(ch_bc[k+1]));
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [17:0] va, input logic [17:0] vb,
                       input logic [47:0] vc, input logic [6:0] m, input logic s);
    a = va; b = vb; c = vc; opmode = m; subtract = s;
  endtask

  task automatic t_reset();
    cyc(1);
    chk("R1 p after reset", p, 48'd0);
    chk("R1 pcout after reset", pcout, 48'd0);
    chk("R1 bcout after reset", {30'd0, bcout}, 48'd0);
  endtask

  task automatic t_product(input logic signed [17:0] va, input logic signed [17:0] vb);
    logic signed [47:0] e;
    e = va * vb;
    drive(va, vb, 48'h0, 7'b000_01_01, 1'b0);
    cyc(2);
    chk("R2 product not ready before latency", p === e && va*vb != 0 ? 48'd1 : 48'd0, 48'd0);
    cyc(1);
    chk("R2 product", p, e);
    chk("R8 bcout after B register", {30'd0, bcout}, {30'd0, vb});
  endtask

  task automatic t_wide();
    logic signed [35:0] ab;
    logic [47:0] e;
    drive(18'h0, 18'h0, 48'h1234_5678_9ABC, 7'b011_00_00, 1'b0);
    cyc(4);
    chk("R4 C passthrough", p, 48'h1234_5678_9ABC);
    drive(18'h3FFFE, 18'h00005, 48'h0000_0000_0100, 7'b000_11_11, 1'b0);
    ab = {18'h3FFFE, 18'h00005};
    e = {{12{ab[35]}}, ab} + 48'h100;
    cyc(4);
    chk("R4 A:B plus C", p, e);
  endtask

  task automatic t_subc();
    logic signed [47:0] e;
    e = 48'sd1000 - 48'sd7 * -48'sd9;
    drive(18'd7, -18'sd9, 48'd1000, 7'b011_01_01, 1'b1);
    cyc(4);
    chk("R3 C minus product", p, e);
    subtract = 1'b0;
    cyc(3);
    chk("R3 C plus product", p, 48'd1000 + 48'(-48'sd63));
  endtask

  task automatic t_wrap();
    drive(18'h0, 18'h0, 48'h7FFF_FFFF_FFFF, 7'b011_11_00, 1'b0);
    cyc(4);
    chk("R10 wrap of C+C", p, 48'hFFFF_FFFF_FFFE);
    drive(18'h0, 18'h0, 48'hFFFF_FFFF_FFFF, 7'b011_11_00, 1'b0);
    cyc(4);
    chk("R10 wrap of -1 + -1", p, 48'hFFFF_FFFF_FFFE);
  endtask

  task automatic t_accum();
    ce_p = 1'b0;
    rst_p = 1'b1;
    cyc(1);
    rst_p = 1'b0;
    drive(18'd3, -18'sd5, 48'h0, 7'b010_01_01, 1'b0);
    cyc(3);
    chk("R9 p held at zero while disabled", p, 48'd0);
    ce_p = 1'b1;
    cyc(5);
    ce_p = 1'b0;
    chk("R5 five accumulations", p, 48'(-48'sd75));
    cyc(3);
    chk("R9 p held while ce_p low", p, 48'(-48'sd75));
    subtract = 1'b1;
    cyc(2);
    ce_p = 1'b1;
    cyc(2);
    ce_p = 1'b0;
    chk("R3 subtractive accumulation", p, 48'(-48'sd45));
    ce_p = 1'b1;
  endtask

  task automatic t_shift(input logic [47:0] v);
    logic [47:0] e;
    e = $signed(v) >>> 17;
    ce_p = 1'b1;
    drive(18'h0, 18'h0, v, 7'b011_00_00, 1'b0);
    cyc(4);
    ce_p = 1'b0;
    opmode = 7'b110_00_00;
    cyc(2);
    ce_p = 1'b1;
    cyc(1);
    ce_p = 1'b0;
    chk("R6 result shifted right by 17", p, e);
    ce_p = 1'b1;
  endtask

  task automatic t_pcin();
    pcin = 48'h0000_0010_0000;
    drive(18'd2, 18'd3, 48'h0, 7'b001_01_01, 1'b0);
    cyc(4);
    chk("R7 pcin plus product", p, 48'h0000_0010_0006);
    chk("R7 pcout equals p", pcout, p);
    pcin = 48'h8000_0000_0000;
    drive(18'd0, 18'd0, 48'h0, 7'b101_00_00, 1'b0);
    cyc(4);
    chk("R6 pcin shifted right by 17", p, 48'hFFFF_C000_0000);
  endtask

  task automatic t_chain();
    logic signed [47:0] e;
    ch_a[0] = 18'd5;  ch_a[1] = -18'sd7; ch_a[2] = 18'd11; ch_a[3] = 18'd2;
    ch_b[0] = -18'sd3;
    for (int k = 1; k < NCH; k++) ch_b[k] = 18'd99;
    ch_mode[0] = 7'b000_01_01;
    for (int k = 1; k < NCH; k++) ch_mode[k] = 7'b001_01_01;
    cyc(16);
    e = -48'sd3 * (48'sd5 - 48'sd7 + 48'sd11 + 48'sd2);
    chk("R7 four-slice cascaded dot product", ch_p[NCH-1], e);
    chk("R8 B from cascade ignores b pin", {30'd0, ch_bc[NCH]}, {30'd0, -18'sd3});
    chk("R7 first partial sum", ch_p[0], 48'(-48'sd15));
  endtask

  initial begin
    rst = 1'b1; rst_p = 1'b0; ce_p = 1'b1; ce_all = 1'b1;
    a = '0; b = '0; bcin = 18'h155; c = '0; pcin = '0;
    opmode = 7'b000_01_01; subtract = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      ch_a[k] = '0; ch_b[k] = '0; ch_mode[k] = 7'b000_01_01;
    end
    cyc(3);
    rst = 1'b0;
    t_reset();
    t_product(18'sd3, -18'sd5);
    t_product(-18'sd131072, -18'sd131072);
    t_product(18'sd131071, -18'sd131072);
    t_wide();
    t_subc();
    t_wrap();
    t_accum();
    t_shift(48'hF000_0000_1234);
    t_shift(48'h0123_4567_89AB);
    t_pcin();
    t_chain();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule